// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a register-mapped peripheral bus. Characters written by software go into an 8-deep transmit queue and are sent as start bit, 7 or 8 data bits (LSB first), optional even or odd parity and one or two stop bits. Received characters go into a 12-deep queue. Each queue entry keeps its byte together with its own parity, framing and overrun flags. Bit timing comes from a 12-bit divisor that is applied to a reference-clock enable, giving 16 sub-bit ticks per bit. The receiver samples each bit at its middle.

Software polls a live status word or takes the single interrupt line. The interrupt reflects two threshold-based queue service requests and three sticky events: receiver idle, break start and break end. The events are cleared by writing 1 to them. A loopback mode routes the transmitter straight into the receiver and holds the serial output idle.

Register offsets on `bus_addr`: 0 format, 1 divisor high nibble, 2 divisor low byte, 3 control, 4 data, 5 events, 6 live status.

Top module: `serial_port_fifo`

## Requirements
- R1: After reset, reads return format 0x08, divisor high 0x0, divisor low 0x17 (23), control 0x03, events 0x00 and live status 0x10. `txd` and `irq` are low-active-free: `txd`=1 and `irq`=0.
- R2: The divisor is 12 bits. Offset 1 writes and reads its upper 4 bits (write data bits [3:0]); offset 2 writes and reads its lower 8 bits. One bit lasts 16*(divisor+1) cycles in which `ref_tick` is high.
- R3: Format register bits are [0] parity enable, [1] odd parity, [2] two stop bits, [3] 8 data bits (else 7). A sent frame is a low start bit, the data LSB first, then the parity bit if enabled (even: XOR of the data bits; odd: its inverse), then one or two high stop bits.
- R4: The transmit queue holds 8 characters, plus the one being shifted. A data write (offset 4) is dropped when the queue is full or the transmitter is disabled. Control bits are [0] transmit enable, [1] receive enable, [2] transmit request enable, [3] receive request enable, [4] loopback.
- R5: The receive queue holds 12 entries. A data read returns {overrun bit 10, framing error bit 9, parity error bit 8, data [7:0]} and pops the entry; a read of an empty queue returns 0. A character that arrives while the queue is full is discarded and sets the overrun bit of the newest stored entry.
- R6: A received parity mismatch sets bit 8 of the entry. A low first stop bit sets bit 9. 7-bit characters read back with bit 7 clear.
- R7: Live status bit 0 (transmit request) is high when the transmit enable and transmit request enable are on and the transmit queue holds 4 or fewer characters. Bit 1 (receive request) is high when the receive enable and receive request enable are on and the receive queue holds more than 4 entries. Bit 2 is high when the transmitter is busy or its queue is non-empty. Bit 3 is high when the receive queue is non-empty. Bit 4 is high when the transmit queue is not full.
- R8: Clearing the receive enable empties the receive queue. Clearing the transmit enable empties the transmit queue; a character already being shifted still completes.
- R9: When the receive queue is non-empty and no character has been stored for three character times, event bit 0 is set, once per stored character. Writing 1 to an event bit clears it.
- R10: A received all-zero character with a low stop bit sets event bit 1 (break start). When the line later returns high, event bit 2 (break end) is set. The break character is stored with its framing bit.
- R11: In loopback mode `txd` stays high and each transmitted character is received as if it had arrived on `rxd`.
- R12: `irq` is high exactly when live status bit 0 or bit 1 is high or any event bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference clock enable feeding the baud divider |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at offset 4) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 11 | Read data for the addressed register |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue pointer or count shows up at the data register within one character. It appears as a repeated, skipped or shuffled byte, or as an overrun flag on the wrong entry. The threshold bits of the live status word and `irq` reveal a count that is off by one as soon as the queue crosses four entries. A wrong bit-phase or frame-length calculation corrupts the very first frame seen on `txd` or read back from `rxd`, because random bytes are decoded bit by bit at mid-bit. A wrong idle timer or break tracker shows up as an event bit that is set a few hundred cycles too early or too late, or that is set again after it was cleared.

// File: rtl/serial_port_fifo.sv
module serial_port_fifo #(
  parameter int TX_DEPTH   = 8,
  parameter int RX_DEPTH   = 12,
  parameter int TX_REQ_MAX = 4,
  parameter int RX_REQ_MIN = 4,
  parameter int DIV_W      = 12,
  parameter int IDLE_CHARS = 3,
  parameter int RESET_DIV  = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [10:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int TXA = $clog2(TX_DEPTH);
  localparam int RXA = $clog2(RX_DEPTH);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int IDW = $clog2(IDLE_CHARS * 16 * 12 + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_st_t;

  function automatic logic [TXA-1:0] tx_wrap(input int v);
    return TXA'(v % TX_DEPTH);
  endfunction
  function automatic logic [RXA-1:0] rx_wrap(input int v);
    return RXA'(v % RX_DEPTH);
  endfunction

  logic [3:0]       fmt;
  logic [DIV_W-1:0] div, bcnt;
  logic [4:0]       ctrl;
  logic [2:0]       evt;

  wire pe = fmt[0], odd = fmt[1], two = fmt[2], d8 = fmt[3];
  wire tx_en = ctrl[0], rx_en = ctrl[1], tx_ie = ctrl[2], rx_ie = ctrl[3], lpbk = ctrl[4];

  wire wr_data = bus_wr && bus_addr == 3'd4;
  wire rd_data = bus_rd && bus_addr == 3'd4;
  wire wr_evt  = bus_wr && bus_addr == 3'd5;
  wire wr_ctl  = bus_wr && bus_addr == 3'd3;

  wire       os_tick = ref_tick && (bcnt >= div);
  wire [3:0] dbits   = d8 ? 4'd8 : 4'd7;
  wire [3:0] nbits   = 4'd9 + {3'd0, d8} + {3'd0, pe} + {3'd0, two};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt  <= 4'b1000;
      div  <= DIV_W'(RESET_DIV);
      ctrl <= 5'b00011;
      bcnt <= '0;
    end else begin
      if (bus_wr && bus_addr == 3'd0) fmt <= bus_wdata[3:0];
      if (bus_wr && bus_addr == 3'd1) div[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
      if (bus_wr && bus_addr == 3'd2) div[7:0] <= bus_wdata;
      if (wr_ctl) ctrl <= bus_wdata[4:0];
      if (ref_tick) bcnt <= os_tick ? '0 : bcnt + 1'b1;
    end
  end

  // transmit queue and shifter
  logic [7:0]     tx_mem [TX_DEPTH];
  logic [TXA-1:0] tx_rd;
  logic [TCW-1:0] tx_cnt;
  logic [11:0]    tx_sh, tx_frame;
  logic [3:0]     tx_left, tx_ph;
  logic [7:0]     tx_dat;

  wire tx_busy = tx_left != 4'd0;
  wire tx_full = tx_cnt == TCW'(TX_DEPTH);
  wire tx_push = wr_data && tx_en && !tx_full;
  wire tx_load = tx_en && !tx_busy && tx_cnt != '0;
  wire tx_line = tx_busy ? tx_sh[0] : 1'b1;
  assign txd = lpbk | tx_line;
  assign tx_dat = d8 ? tx_mem[tx_rd] : {1'b0, tx_mem[tx_rd][6:0]};

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    tx_frame[8:1] = tx_dat;
    if (!d8) tx_frame[8] = 1'b1;
    if (pe) tx_frame[dbits + 4'd1] = ^tx_dat ^ odd;
  end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wrap(int'(tx_rd) + int'(tx_cnt))] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rd <= '0; tx_cnt <= '0;
      tx_sh <= '1; tx_left <= '0; tx_ph <= '0;
    end else begin
      if (!tx_en) tx_cnt <= '0;
      else begin
        if (tx_load) tx_rd <= tx_wrap(int'(tx_rd) + 1);
        tx_cnt <= tx_cnt + TCW'(tx_push) - TCW'(tx_load);
      end
      if (tx_load) begin
        tx_sh <= tx_frame; tx_left <= nbits; tx_ph <= '0;
      end else if (tx_busy && os_tick) begin
        tx_ph <= tx_ph + 4'd1;
        if (tx_ph == 4'd15) begin
          tx_sh <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
        end
      end
    end
  end

  // receiver
  rx_st_t      rx_st;
  logic        rx_s1, rx_s2, in_brk;
  logic [3:0]  rx_ph, rx_idx;
  logic [11:0] rx_sh, rx_all;
  logic [7:0]  rx_dat;

  always_comb begin
    rx_all = rx_sh;
    rx_all[rx_idx] = rx_s2;
  end

  wire rx_last = rx_st == RX_BITS && os_tick && rx_ph == 4'd15 && rx_idx == nbits - 4'd2;
  assign rx_dat = d8 ? rx_all[7:0] : {1'b0, rx_all[6:0]};
  wire rx_par   = rx_all[dbits];
  wire perr     = pe && (rx_par ^ (^rx_dat) ^ odd);
  wire ferr     = !rx_all[dbits + {3'd0, pe}];
  wire brk      = ferr && rx_dat == 8'd0 && !(pe && rx_par);
  wire brk_end  = rx_st == RX_HOLD && rx_s2 && in_brk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_s1 <= 1'b1; rx_s2 <= 1'b1; in_brk <= 1'b0;
      rx_ph <= '0; rx_idx <= '0; rx_sh <= '0;
    end else begin
      rx_s1 <= lpbk ? tx_line : rxd;
      rx_s2 <= rx_s1;
      if (rx_last && brk) in_brk <= 1'b1;
      else if (brk_end) in_brk <= 1'b0;
      case (rx_st)
        RX_IDLE: if (!rx_s2) begin rx_st <= RX_START; rx_ph <= '0; end
        RX_START: if (os_tick) begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd7) begin
            rx_ph <= '0; rx_idx <= '0;
            rx_st <= rx_s2 ? RX_IDLE : RX_BITS;
          end
        end
        RX_BITS: if (os_tick) begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd15) begin
            rx_sh <= rx_all;
            rx_idx <= rx_idx + 4'd1;
            if (rx_last) rx_st <= RX_HOLD;
          end
        end
        default: if (rx_s2) rx_st <= RX_IDLE;
      endcase
    end
  end

  // receive queue
  logic [10:0]    rx_mem [RX_DEPTH];
  logic [RXA-1:0] rx_rd;
  logic [RCW-1:0] rx_cnt;

  wire rx_full  = rx_cnt == RCW'(RX_DEPTH);
  wire rx_pop   = rd_data && rx_cnt != '0;
  wire rx_push  = rx_last && rx_en;
  wire rx_store = rx_push && (!rx_full || rx_pop);

  always_ff @(posedge clk)
    if (rx_store) rx_mem[rx_wrap(int'(rx_rd) + int'(rx_cnt))] <= {1'b0, ferr, perr, rx_dat};
    else if (rx_push && rx_full)
      rx_mem[rx_wrap(int'(rx_rd) + int'(rx_cnt) + RX_DEPTH - 1)][10] <= 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rd <= '0; rx_cnt <= '0;
    end else if (!rx_en) rx_cnt <= '0;
    else begin
      if (rx_pop) rx_rd <= rx_wrap(int'(rx_rd) + 1);
      rx_cnt <= rx_cnt + RCW'(rx_store) - RCW'(rx_pop);
    end
  end

  // idle timer and events
  logic [IDW-1:0] idle_cnt;
  wire [IDW-1:0] idle_lim = IDW'(IDLE_CHARS * 16 * int'(nbits));
  wire idle_set = os_tick && rx_cnt != '0 && !rx_store && idle_cnt == idle_lim - IDW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0; evt <= '0;
    end else begin
      if (rx_store || rx_cnt == '0) idle_cnt <= '0;
      else if (os_tick && idle_cnt != idle_lim) idle_cnt <= idle_cnt + IDW'(1);
      evt <= (evt & ~(wr_evt ? bus_wdata[2:0] : 3'b000)) | {brk_end, rx_last && brk, idle_set};
    end
  end

  wire tx_req = tx_en && tx_ie && tx_cnt <= TCW'(TX_REQ_MAX);
  wire rx_req = rx_en && rx_ie && rx_cnt > RCW'(RX_REQ_MIN);
  wire [7:0] live = {3'b000, !tx_full, rx_cnt != '0, tx_busy || tx_cnt != '0, rx_req, tx_req};
  assign irq = tx_req | rx_req | (|evt);

  always_comb
    case (bus_addr)
      3'd0:    bus_rdata = 11'(fmt);
      3'd1:    bus_rdata = 11'(div[DIV_W-1:8]);
      3'd2:    bus_rdata = 11'(div[7:0]);
      3'd3:    bus_rdata = 11'(ctrl);
      3'd4:    bus_rdata = rx_cnt != '0 ? rx_mem[rx_rd] : 11'd0;
      3'd5:    bus_rdata = 11'(evt);
      3'd6:    bus_rdata = 11'(live);
      default: bus_rdata = 11'd0;
    endcase

  p_txcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TCW'(TX_DEPTH));
  p_tx_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_load) |=> tx_cnt == TCW'(TX_DEPTH));
  p_rxcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RCW'(RX_DEPTH));
  p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_pop && !wr_ctl) |=> rx_full);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> rx_cnt == '0);
  p_event_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !(wr_evt && bus_wdata[0])) |=> evt[0]);
endmodule

// File: tb/test_serial_port_fifo.sv
module test_serial_port_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ref_tick = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, rxd = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [10:0] bus_rdata;
  logic txd, irq;

  serial_port_fifo i_serial_port_fifo (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  int n_chk = 0, n_err = 0;
  int mon_bt = 16, mon_n = 9;
  logic [11:0] mon_q[$];
  logic [10:0] rv;
  logic [7:0]  dk[13];
  logic [3:0]  fm;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [10:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] mask_d(input logic [7:0] d, input logic [3:0] f);
    return f[3] ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic [11:0] exp_tx(input logic [7:0] d, input logic [3:0] f);
    logic [11:0] r = '0;
    int k = 0;
    logic [7:0] m = mask_d(d, f);
    for (int i = 0; i < (f[3] ? 8 : 7); i++) r[k++] = m[i];
    if (f[0]) r[k++] = (^m) ^ f[1];
    r[k++] = 1'b1;
    if (f[2]) r[k++] = 1'b1;
    return r;
  endfunction

  function automatic int frame_bits(input logic [3:0] f);
    return 1 + (f[3] ? 8 : 7) + int'(f[0]) + (f[2] ? 2 : 1);
  endfunction

  function automatic logic [10:0] exp_rx(input logic [7:0] d, input logic [3:0] f, input bit bp, input bit bs);
    return {1'b0, bs, bp & f[0], mask_d(d, f)};
  endfunction

  task automatic send_rx(input logic [7:0] d, input logic [3:0] f, input bit bp, input bit bs);
    logic [7:0] m = mask_d(d, f);
    rxd = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < (f[3] ? 8 : 7); i++) begin rxd = m[i]; repeat (16) @(negedge clk); end
    if (f[0]) begin rxd = (^m) ^ f[1] ^ bp; repeat (16) @(negedge clk); end
    rxd = !bs; repeat (16) @(negedge clk);
    rxd = 1'b1; repeat (f[2] ? 32 : 16) @(negedge clk);
  endtask

  task automatic wait_q(input int n, input int maxc);
    for (int c = 0; c < maxc && mon_q.size() < n; c++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin : cap
        logic [11:0] b;
        b = '0;
        repeat (mon_bt / 2 - 1) @(negedge clk);
        for (int i = 0; i < mon_n; i++) begin
          repeat (mon_bt) @(negedge clk);
          b[i] = txd;
        end
        mon_q.push_back(b);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(3'd0, rv); check("R1 format", rv, 11'h08);
    bus_read(3'd1, rv); check("R1 div hi", rv, 11'h0);
    bus_read(3'd2, rv); check("R1 div lo", rv, 11'd23);
    bus_read(3'd3, rv); check("R1 ctrl", rv, 11'h03);
    bus_read(3'd5, rv); check("R1 events", rv, 11'h0);
    bus_read(3'd6, rv); check("R1 live", rv, 11'h10);
    check("R1 irq", irq, 0);
    check("R1 txd", txd, 1);

    // R3 transmit 8N1, random bytes
    bus_write(3'd2, 8'd0);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = 8'($urandom);
      mon_q.delete();
      bus_write(3'd4, d);
      wait_q(1, 400);
      check("R3 8N1 frame", mon_q.size() ? mon_q[0] : 12'hfff, exp_tx(d, 4'h8));
    end
    // R3 seven data bits, odd parity, two stops
    bus_write(3'd0, 8'h07); mon_n = frame_bits(4'h7) - 1;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] d = 8'($urandom);
      mon_q.delete();
      bus_write(3'd4, d);
      wait_q(1, 400);
      check("R3 7O2 frame", mon_q.size() ? mon_q[0] : 12'hfff, exp_tx(d, 4'h7));
    end
    repeat (40) @(negedge clk);
    // R2 divisor split and bit time
    bus_write(3'd0, 8'h08); mon_n = 9;
    bus_write(3'd1, 8'hA5);
    bus_read(3'd1, rv); check("R2 div hi nibble", rv, 11'h5);
    bus_write(3'd1, 8'h00); bus_write(3'd2, 8'd1); mon_bt = 32;
    for (int i = 0; i < 2; i++) begin
      logic [7:0] d = 8'($urandom);
      mon_q.delete();
      bus_write(3'd4, d);
      wait_q(1, 800);
      check("R2 slow frame", mon_q.size() ? mon_q[0] : 12'hfff, exp_tx(d, 4'h8));
    end
    repeat (80) @(negedge clk);
    bus_write(3'd2, 8'd0); mon_bt = 16;

    // R4 / R7 / R12 transmit full, drop, request threshold
    bus_write(3'd3, 8'h07);
    check("R12 irq from tx request", irq, 1);
    mon_q.delete();
    for (int i = 0; i < 12; i++) begin dk[i] = 8'($urandom); bus_write(3'd4, dk[i]); end
    bus_read(3'd6, rv);
    check("R7 tx request low when 8 queued", rv[0], 0);
    check("R4 tx full flag", rv[4], 0);
    wait_q(9, 2200);
    repeat (400) @(negedge clk);
    check("R4 frames sent after overfill", mon_q.size(), 9);
    for (int i = 0; i < 9; i++)
      check("R4 queued order", i < mon_q.size() ? mon_q[i] : 12'hfff, exp_tx(dk[i], 4'h8));
    bus_read(3'd6, rv); check("R7 tx request after drain", rv[0], 1);
    // R4 dropped while disabled
    bus_write(3'd3, 8'h02); mon_q.delete();
    bus_write(3'd4, 8'h5A);
    repeat (300) @(negedge clk);
    check("R4 disabled write dropped", mon_q.size(), 0);
    bus_read(3'd6, rv); check("R4 tx idle", rv[2], 0);
    // R8 transmit flush
    bus_write(3'd3, 8'h03);
    for (int i = 0; i < 5; i++) begin dk[i] = 8'($urandom); bus_write(3'd4, dk[i]); end
    bus_write(3'd3, 8'h02); bus_write(3'd3, 8'h03);
    repeat (1000) @(negedge clk);
    check("R8 tx flush count", mon_q.size(), 1);
    check("R8 tx shifter completes", mon_q.size() ? mon_q[0] : 12'hfff, exp_tx(dk[0], 4'h8));

    // R5 / R7 / R12 receive
    bus_write(3'd3, 8'h0B);
    for (int i = 0; i < 5; i++) begin dk[i] = 8'($urandom); send_rx(dk[i], 4'h8, 0, 0); end
    bus_read(3'd6, rv);
    check("R7 rx request above 4", rv[1], 1);
    check("R12 irq from rx request", irq, 1);
    bus_read(3'd4, rv); check("R5 rx entry", rv, exp_rx(dk[0], 4'h8, 0, 0));
    bus_read(3'd6, rv); check("R7 rx request at 4", rv[1], 0);
    for (int i = 1; i < 5; i++) begin bus_read(3'd4, rv); check("R5 rx entry", rv, exp_rx(dk[i], 4'h8, 0, 0)); end

    // R6 parity and framing errors
    for (int p = 0; p < 2; p++) begin
      fm = p ? 4'hB : 4'h9;
      bus_write(3'd0, 8'(fm));
      dk[0] = 8'($urandom); dk[1] = 8'($urandom) | 8'h01; dk[2] = 8'($urandom);
      send_rx(dk[0], fm, 1, 0); send_rx(dk[1], fm, 0, 1); send_rx(dk[2], fm, 0, 0);
      bus_read(3'd4, rv); check("R6 parity error", rv, exp_rx(dk[0], fm, 1, 0));
      bus_read(3'd4, rv); check("R6 framing error", rv, exp_rx(dk[1], fm, 0, 1));
      bus_read(3'd4, rv); check("R6 clean", rv, exp_rx(dk[2], fm, 0, 0));
    end
    bus_write(3'd0, 8'h00);
    send_rx(8'hFF, 4'h0, 0, 0);
    bus_read(3'd4, rv); check("R6 seven-bit read", rv, 11'h07F);
    bus_write(3'd0, 8'h08);

    // R5 overrun
    for (int i = 0; i < 13; i++) begin dk[i] = 8'($urandom); send_rx(dk[i], 4'h8, 0, 0); end
    for (int i = 0; i < 12; i++) begin
      bus_read(3'd4, rv);
      check("R5 overrun entries", rv, {i == 11, 2'b00, dk[i]});
    end
    bus_read(3'd4, rv); check("R5 empty read", rv, 0);

    // R9 idle event
    bus_write(3'd5, 8'h07);
    send_rx(8'h3C, 4'h8, 0, 0);
    bus_write(3'd5, 8'h07);
    repeat (300) @(negedge clk);
    bus_read(3'd5, rv); check("R9 idle not yet", rv, 0);
    check("R12 irq quiet", irq, 0);
    repeat (300) @(negedge clk);
    bus_read(3'd5, rv); check("R9 idle set", rv, 1);
    check("R12 irq from event", irq, 1);
    bus_write(3'd5, 8'h01);
    repeat (600) @(negedge clk);
    bus_read(3'd5, rv); check("R9 cleared once", rv, 0);
    bus_read(3'd4, rv); check("R9 data kept", rv, 11'h03C);

    // R10 break
    rxd = 1'b0; repeat (400) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    bus_read(3'd5, rv); check("R10 break events", rv, 11'h6);
    bus_read(3'd4, rv); check("R10 break entry", rv, 11'h200);
    bus_write(3'd5, 8'h07);

    // R11 loopback with random formats
    bus_write(3'd3, 8'h13);
    for (int i = 0; i < 6; i++) begin
      int lows = 0;
      logic [7:0] d = 8'($urandom);
      fm = 4'($urandom);
      bus_write(3'd0, 8'(fm));
      bus_write(3'd4, d);
      repeat (250) begin @(negedge clk); if (!txd) lows++; end
      check("R11 txd held idle", lows, 0);
      bus_read(3'd4, rv); check("R11 loopback entry", rv, exp_rx(d, fm, 0, 0));
    end
    bus_write(3'd0, 8'h08);

    // R8 receive flush
    bus_write(3'd3, 8'h03);
    send_rx(8'h11, 4'h8, 0, 0); send_rx(8'h22, 4'h8, 0, 0);
    bus_read(3'd6, rv); check("R8 rx non-empty", rv[3], 1);
    bus_write(3'd3, 8'h01); bus_write(3'd3, 8'h03);
    bus_read(3'd6, rv); check("R8 rx flushed", rv[3], 0);
    bus_read(3'd4, rv); check("R8 rx flushed read", rv, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule